// File: doc/BRIEF.md
# Overcurrent Fault Latch with Timed Clear

This block watches two digital flags from the power stage. One is an overcurrent comparator output and the other is a logic-supply undervoltage indication. From them it derives an active-low fault line and a shutdown request that turns off every gate output of a three-phase bridge.

An overcurrent trip is captured in a latch in which the set input wins. The fault stays asserted while the trip persists. Once the trip ends, the fault is held for a programmable number of clock cycles and then released without any software action.

Switching edges on the bridge produce short current spikes. For that reason, trips seen in a short blanking window after each switching-edge strobe are discarded. An undervoltage forces the fault and the shutdown for exactly as long as it lasts and leaves no memory behind.

Top module: `oc_fault_guard`

## Requirements
- R1: While reset is asserted and right after it is released, with no input active, `fault_no` is 1 and `shutdown_o` is 0.
- R2: An overcurrent trip that is not blanked, sampled on a clock edge, drives `fault_no` to 0 and `shutdown_o` to 1 from the next cycle.
- R3: While the overcurrent flag stays high and is not blanked, the fault stays set, however short the programmed delay.
- R4: With delay value N sampled in the last trip cycle, the fault stays set for exactly max(N,1) cycles after that cycle and is released in the following cycle. A value of 0 behaves like 1.
- R5: A new trip while the clear countdown is running restarts the hold. The new hold is measured from the new trip and uses the delay value sampled in that trip cycle.
- R6: A trip sampled in the same cycle as a switching-edge strobe, or in any of the next BLANK_CYCLES cycles, has no effect on the outputs. A new strobe during the window restarts it, and a trip in the first cycle after the window is honoured.
- R7: While `uv_i` is 1, `fault_no` is 0 and `shutdown_o` is 1 in the same cycle. When `uv_i` returns to 0, the outputs are freed at once unless an overcurrent fault is held.
- R8: An undervoltage pulse neither starts nor extends nor cuts short an overcurrent hold.
- R9: Changes on `clr_delay_i` while the countdown runs without a new trip do not change the release cycle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| oc_trip_i | input | 1 | Overcurrent comparator flag, active high |
| uv_i | input | 1 | Logic-supply undervoltage flag, active high |
| sw_edge_i | input | 1 | One-cycle strobe marking a bridge switching edge |
| clr_delay_i | input | CNT_W | Clear hold length in cycles, sampled on every accepted trip |
| fault_no | output | 1 | Fault indication, 0 while a fault is present, released to 1 otherwise |
| shutdown_o | output | 1 | Request to turn off all gate outputs |

## Verification
The bench builds the block with BLANK_CYCLES=3 and an 8-bit delay. This keeps every blanking window and hold only a handful of cycles long, so the exact edges of each window can be probed one cycle at a time. With the short delays, a retrigger can land inside a running countdown with both a longer and a shorter new value, and the zero-delay corner is reached. An undervoltage pulse can also be placed before, inside and across a hold within a few dozen cycles.

// File: rtl/oc_guard_pkg.sv
package oc_guard_pkg;

    typedef enum logic [1:0] {
        FG_CLEAR    = 2'd0,
        FG_TRIPPED  = 2'd1,
        FG_COUNTING = 2'd2
    } fg_state_e;

    function automatic int unsigned blank_width(input int unsigned cycles);
        return (cycles < 1) ? 1 : $clog2(cycles + 1);
    endfunction

endpackage

// File: rtl/oc_blank_window.sv
module oc_blank_window #(
    parameter int unsigned BLANK_CYCLES = 4
) (
    input  logic clk_i,
    input  logic rst_ni,
    input  logic sw_edge_i,
    output logic blank_o
);
    import oc_guard_pkg::*;

    localparam int unsigned BW = blank_width(BLANK_CYCLES);
    localparam logic [BW-1:0] LOAD = BW'(BLANK_CYCLES);

    typedef struct packed {
        logic [BW-1:0] left;
    } blank_t;

    blank_t st_d, st_q;

    always_comb begin
        st_d = st_q;
        if (sw_edge_i) begin
            st_d.left = LOAD;
        end else if (st_q.left != '0) begin
            st_d.left = st_q.left - BW'(1);
        end
    end

    always_ff @(posedge clk_i or negedge rst_ni) begin
        if (!rst_ni) begin
            st_q <= '0;
        end else begin
            st_q <= st_d;
        end
    end

    assign blank_o = sw_edge_i || (st_q.left != '0);

endmodule

// File: rtl/oc_clear_timer.sv
module oc_clear_timer #(
    parameter int unsigned CNT_W = 24
) (
    input  logic             clk_i,
    input  logic             rst_ni,
    input  logic             trip_i,
    input  logic [CNT_W-1:0] delay_i,
    output logic             latched_o
);
    import oc_guard_pkg::*;

    typedef struct packed {
        fg_state_e        state;
        logic [CNT_W-1:0] cnt;
    } timer_t;

    timer_t st_d, st_q;

    always_comb begin
        st_d = st_q;
        if (trip_i) begin
            st_d.state = FG_TRIPPED;
            st_d.cnt   = delay_i;
        end else begin
            case (st_q.state)
                FG_TRIPPED, FG_COUNTING: begin
                    if (st_q.cnt <= CNT_W'(1)) begin
                        st_d.state = FG_CLEAR;
                        st_d.cnt   = '0;
                    end else begin
                        st_d.state = FG_COUNTING;
                        st_d.cnt   = st_q.cnt - CNT_W'(1);
                    end
                end
                default: begin
                    st_d.state = FG_CLEAR;
                    st_d.cnt   = '0;
                end
            endcase
        end
    end

    always_ff @(posedge clk_i or negedge rst_ni) begin
        if (!rst_ni) begin
            st_q <= '{state: FG_CLEAR, cnt: '0};
        end else begin
            st_q <= st_d;
        end
    end

    assign latched_o = (st_q.state != FG_CLEAR);

endmodule

// File: rtl/oc_fault_guard.sv
module oc_fault_guard #(
    parameter int unsigned BLANK_CYCLES = 4,
    parameter int unsigned CNT_W        = 24
) (
    input  logic             clk_i,
    input  logic             rst_ni,
    input  logic             oc_trip_i,
    input  logic             uv_i,
    input  logic             sw_edge_i,
    input  logic [CNT_W-1:0] clr_delay_i,
    output logic             fault_no,
    output logic             shutdown_o
);
    logic blank;
    logic trip_ok;
    logic fault_latched;

    oc_blank_window #(
        .BLANK_CYCLES(BLANK_CYCLES)
    ) u_blank (
        .clk_i    (clk_i),
        .rst_ni   (rst_ni),
        .sw_edge_i(sw_edge_i),
        .blank_o  (blank)
    );

    assign trip_ok = oc_trip_i && !blank;

    oc_clear_timer #(
        .CNT_W(CNT_W)
    ) u_timer (
        .clk_i    (clk_i),
        .rst_ni   (rst_ni),
        .trip_i   (trip_ok),
        .delay_i  (clr_delay_i),
        .latched_o(fault_latched)
    );

    assign shutdown_o = fault_latched || uv_i;
    assign fault_no   = !(fault_latched || uv_i);

endmodule

// File: rtl/oc_fault_guard_chk.sv
module oc_fault_guard_chk (
    input logic clk_i,
    input logic rst_ni,
    input logic oc_trip_i,
    input logic uv_i,
    input logic sw_edge_i,
    input logic trip_ok,
    input logic fault_latched,
    input logic fault_no,
    input logic shutdown_o
);
    // R2: both outputs always tell the same story
    p_polarity_r2: assert property (@(posedge clk_i) disable iff (!rst_ni)
        fault_no != shutdown_o);

    // R2, R3: an accepted trip leaves the fault held next cycle
    p_set_dominant_r3: assert property (@(posedge clk_i) disable iff (!rst_ni)
        (oc_trip_i && trip_ok) |=> (fault_latched && !fault_no));

    // R4: the hold never ends in the cycle right after an accepted trip
    p_no_early_clear_r4: assert property (@(posedge clk_i) disable iff (!rst_ni)
        $fell(fault_latched) |-> !$past(trip_ok));

    // R6: a strobe cycle never passes a trip
    p_edge_blanks_r6: assert property (@(posedge clk_i) disable iff (!rst_ni)
        sw_edge_i |-> !trip_ok);

    // R7: undervoltage forces the outputs in the same cycle
    p_uv_forces_r7: assert property (@(posedge clk_i) disable iff (!rst_ni)
        uv_i |-> (!fault_no && shutdown_o));

endmodule

bind oc_fault_guard oc_fault_guard_chk u_chk (
    .clk_i        (clk_i),
    .rst_ni       (rst_ni),
    .oc_trip_i    (oc_trip_i),
    .uv_i         (uv_i),
    .sw_edge_i    (sw_edge_i),
    .trip_ok      (trip_ok),
    .fault_latched(fault_latched),
    .fault_no     (fault_no),
    .shutdown_o   (shutdown_o)
);

// File: tb/oc_fault_guard_bench.sv
module oc_fault_guard_bench;
    localparam int PERIOD = 10;
    localparam int BLANK  = 3;
    localparam int CW     = 8;

    logic          clk = 1'b0;
    logic          rst_ni = 1'b0;
    logic          oc = 1'b0, uv = 1'b0, edge_s = 1'b0;
    logic [CW-1:0] dly = '0;
    logic          fault_no, shutdown_o;

    int    checks = 0, errors = 0;
    string cur_req = "R1";

    // behavioural reference state
    int cyc = 0;
    int last_edge = -1;
    int last_trip = -1;
    int last_n = 0;
    bit done = 0;

    always #(PERIOD/2) clk = ~clk;

    oc_fault_guard #(.BLANK_CYCLES(BLANK), .CNT_W(CW)) u_oc_fault_guard (
        .clk_i(clk), .rst_ni(rst_ni), .oc_trip_i(oc), .uv_i(uv),
        .sw_edge_i(edge_s), .clr_delay_i(dly),
        .fault_no(fault_no), .shutdown_o(shutdown_o)
    );

    always @(posedge clk or negedge rst_ni) begin
        if (!rst_ni) begin
            cyc = 0; last_edge = -1; last_trip = -1; last_n = 0;
        end else begin
            if (edge_s) last_edge = cyc;
            if (oc && !(last_edge >= 0 && cyc - last_edge <= BLANK)) begin
                last_trip = cyc;
                last_n    = int'(dly);
            end
            cyc = cyc + 1;
        end
    end

    function automatic bit model_latched();
        int age, hold;
        if (last_trip < 0) return 0;
        age  = cyc - last_trip;
        hold = (last_n < 1) ? 1 : last_n;
        return (age >= 1) && (age <= hold);
    endfunction

    always @(negedge clk) begin
        if (rst_ni && !done) begin
            bit exp_sd;
            exp_sd = model_latched() || uv;
            checks++;
            if (shutdown_o !== exp_sd || fault_no !== !exp_sd) begin
                errors++;
                $display("FAIL %s cycle %0d: shutdown=%b fault_n=%b expected shutdown=%b fault_n=%b",
                         cur_req, cyc, shutdown_o, fault_no, exp_sd, !exp_sd);
            end
        end
    end

    task automatic drive(input bit t, input bit u, input bit e, input int d, input int n);
        for (int i = 0; i < n; i++) begin
            @(posedge clk); #1;
            oc = t; uv = u; edge_s = e; dly = CW'(d);
        end
    endtask

    task automatic idle(input int n);
        drive(0, 0, 0, 0, n);
    endtask

    initial begin
        fork
            begin
                #(PERIOD * 200000);
                errors++; checks++;
                $display("FAIL watchdog expired");
                done = 1;
                $display("Result: errors=%0d of %0d checks", errors, checks);
                $finish;
            end
        join_none

        // R1: reset state
        #(PERIOD*2 + 2);
        checks++;
        if (fault_no !== 1'b1 || shutdown_o !== 1'b0) begin
            errors++;
            $display("FAIL R1 in reset: fault_n=%b shutdown=%b expected 1 0", fault_no, shutdown_o);
        end
        @(posedge clk); #1 rst_ni = 1'b1;
        idle(3);

        cur_req = "R2"; drive(1, 0, 0, 4, 1); idle(8);
        cur_req = "R4"; drive(1, 0, 0, 1, 1); idle(4);
        drive(1, 0, 0, 0, 1); idle(4);
        cur_req = "R3"; drive(1, 0, 0, 2, 10); idle(6);
        cur_req = "R5"; drive(1, 0, 0, 6, 1); idle(3);
        drive(1, 0, 0, 2, 1); idle(5);
        drive(1, 0, 0, 2, 1); idle(1);
        drive(1, 0, 0, 7, 1); idle(10);
        cur_req = "R9"; drive(1, 0, 0, 5, 1);
        drive(0, 0, 0, 200, 2); drive(0, 0, 0, 1, 2); idle(5);

        cur_req = "R6";
        drive(1, 0, 1, 3, 1); drive(1, 0, 0, 3, BLANK); drive(0, 0, 0, 3, 1); idle(6);
        drive(0, 0, 1, 3, 1); drive(1, 0, 0, 3, BLANK); drive(1, 0, 0, 3, 1); idle(6);
        drive(0, 0, 1, 3, 1); drive(1, 0, 0, 3, 2); drive(1, 0, 1, 3, 1);
        drive(1, 0, 0, 3, BLANK); drive(0, 0, 0, 3, 1); idle(6);
        drive(1, 0, 1, 4, 1); drive(1, 0, 0, 4, BLANK + 3); idle(8);

        cur_req = "R7"; drive(0, 1, 0, 0, 3); idle(3);
        drive(0, 1, 0, 0, 1); idle(2);
        cur_req = "R8"; drive(1, 0, 0, 6, 1); idle(1); drive(0, 1, 0, 0, 2); idle(8);
        drive(0, 1, 0, 3, 2); drive(1, 1, 0, 3, 1); drive(0, 1, 0, 3, 5); idle(4);
        drive(1, 0, 0, 2, 1); drive(0, 1, 0, 0, 6); idle(4);

        done = 1;
        $display("Result: errors=%0d of %0d checks", errors, checks);
        $finish;
    end
endmodule